// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an up-counter advanced by a programmable division of the peripheral clock. It has two modes. As a watchdog, software must reload the counter before it wraps. If the counter wraps, the block sets a watchdog flag and sends a one-cycle reset request to the system reset logic. As an interval timer, each wrap sets an interval flag and raises an interrupt request. The request stays high until software clears the flag.

Software reaches the block through a small register port with one write strobe and a one-bit address. Address 0 is the counter and address 1 is the control/status word. The divider runs freely from reset and is never restarted. Because of this, the first count after the timer is enabled can arrive early. Every count after that arrives at the full selected period. Software should change the divider code only while the timer is stopped. The block discards a divider code written while the timer runs.

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0x00, and both `wdt_rst_req` and `itv_irq` are low.
- R2: The clock-select code picks the spacing between counter increments. The spacings in peripheral clock cycles are: code 0 → 1, 1 → 4, 2 → 16, 3 → 32, 4 → 64, 5 → 256, 6 → 1024, 7 → 4096.
- R3: The counter advances only while the run bit is 1. While the run bit is 0, the counter holds its value.
- R4: An increment from the counter's maximum value (0xFF) is an overflow. The counter wraps to 0x00 and keeps counting.
- R5: An overflow in watchdog mode (mode bit 1) sets the watchdog flag. It also drives `wdt_rst_req` high for exactly one cycle: the cycle after the wrap edge. The interval flag is not affected.
- R6: An overflow in interval mode (mode bit 0) sets the interval flag and leaves the watchdog flag alone. It never pulses `wdt_rst_req`. `itv_irq` is high exactly while the interval flag is set.
- R7: Writing 0 to a flag bit of the control word clears that flag, and writing 1 leaves it unchanged. If an overflow happens in the same cycle as a clear, the flag ends up set.
- R8: The clock-select field is written only while the run bit is currently 0. A code written while the timer runs is discarded.
- R9: Writing address 0 loads the counter with the written value on the next edge. This load takes precedence over an increment in the same cycle.
- R10: The control word layout is: bit 7 mode (1 = watchdog), bit 6 run, bit 5 reads 0, bit 4 watchdog flag, bit 3 interval flag, bits 2:0 clock-select code. The mode and run bits always take the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 counter, 1 control word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| wdt_rst_req | output | 1 | One-cycle reset request on a watchdog-mode overflow |
| itv_irq | output | 1 | Interrupt request, high while the interval flag is set |

## Verification
The bench steps through all eight clock-select codes and times the gap between two counter increments after the first one. This exposes a tap that is off by one bit, which would show up as a doubled or halved period. Overflows are forced in both modes from a counter loaded near its limit. A design that sets the wrong flag, holds the reset request for two cycles, or lets the interrupt drop on its own would show that at the ports. The bench also clears the interval flag on the same edge as an overflow, where a design that favours the clear would lose the event. It writes a new divider code while the timer runs, where a design that accepts it would change the increment rate.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Clock-select field width and the number of divider taps it can pick.
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned SEL_CODES = 1 << SEL_W;

   // Bit positions inside the control/status word.
   localparam int unsigned CTL_MODE    = 7;
   localparam int unsigned CTL_RUN     = 6;
   localparam int unsigned CTL_WFLAG   = 4;
   localparam int unsigned CTL_IFLAG   = 3;
   localparam int unsigned CTL_SEL_LSB = 0;

   // Register addresses.
   localparam logic ADDR_CNT = 1'b0;
   localparam logic ADDR_CTL = 1'b1;

   // log2 of the divide ratio for each clock-select code.
   function automatic int unsigned tap_shift(input int unsigned code);
      case (code)
         0:       return 0;
         1:       return 2;
         2:       return 4;
         3:       return 5;
         4:       return 6;
         5:       return 8;
         6:       return 10;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int unsigned PRE_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [wdt_pkg::SEL_W-1:0] sel,
   output logic                     tick
);
   import wdt_pkg::*;

   localparam int unsigned MAX_SHIFT = tap_shift(SEL_CODES - 1);

   if (MAX_SHIFT > PRE_W) begin : g_chk_width
      $error("wdt_prescaler: PRE_W too small for the longest divide ratio");
   end

   logic [PRE_W-1:0]     div_q;
   logic [SEL_CODES-1:0] tap;

   // Free-running divider: it is never restarted by the timer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   // One enable pulse per 2**shift cycles for each tap.
   for (genvar i = 0; i < SEL_CODES; i++) begin : g_tap
      localparam int unsigned SH = tap_shift(i);
      if (SH == 0) begin : g_full
         assign tap[i] = 1'b1;
      end else begin : g_div
         assign tap[i] = &div_q[SH-1:0];
      end
   end

   assign tick = tap[sel];

   // R2: the undivided code enables every cycle.
   p_full_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> tick);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   if (CNT_W < 2) begin : g_chk_width
      $error("wdt_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step = run & tick & ~ld;
   assign ovf  = step & (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (ld)   cnt_q <= ld_val;
      else if (step) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R3: a stopped counter that is not loaded keeps its value.
   p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld) |=> $stable(cnt_q));

   // R4: an overflow leaves the counter at zero.
   p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (cnt_q == '0));

   // R9: a load wins over any increment.
   p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs #(
   parameter int unsigned DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [DATA_W-1:0]         wdata,
   input  logic                      ovf,
   output logic                      run,
   output logic [wdt_pkg::SEL_W-1:0] csel,
   output logic [DATA_W-1:0]         rdata,
   output logic                      rst_req,
   output logic                      irq
);
   import wdt_pkg::*;

   if (DATA_W < 8) begin : g_chk_width
      $error("wdt_ctrl_regs: control word needs at least 8 bits");
   end

   logic             wd_q, run_q, wflag_q, iflag_q, rst_req_q;
   logic [SEL_W-1:0] csel_q;
   logic             wflag_nxt, iflag_nxt, wclr, iclr;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;

   // Write of 0 clears a flag; a coincident overflow sets it anyway.
   assign wclr      = wr & ~wdata[CTL_WFLAG];
   assign iclr      = wr & ~wdata[CTL_IFLAG];
   assign wflag_nxt = (ovf &  wd_q) | (wflag_q & ~wclr);
   assign iflag_nxt = (ovf & ~wd_q) | (iflag_q & ~iclr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q      <= 1'b0;
         run_q     <= 1'b0;
         csel_q    <= '0;
         wflag_q   <= 1'b0;
         iflag_q   <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         if (wr) begin
            wd_q  <= wdata[CTL_MODE];
            run_q <= wdata[CTL_RUN];
            if (!run_q) csel_q <= wdata[CTL_SEL_LSB +: SEL_W];
         end
         wflag_q   <= wflag_nxt;
         iflag_q   <= iflag_nxt;
         rst_req_q <= ovf & wd_q;
      end
   end

   always_comb begin
      rdata                         = '0;
      rdata[CTL_MODE]               = wd_q;
      rdata[CTL_RUN]                = run_q;
      rdata[CTL_WFLAG]              = wflag_q;
      rdata[CTL_IFLAG]              = iflag_q;
      rdata[CTL_SEL_LSB +: SEL_W]   = csel_q;
   end

   assign run     = run_q;
   assign csel    = csel_q;
   assign rst_req = rst_req_q;
   assign irq     = iflag_q;

   // R5: watchdog flag rises only after a watchdog-mode overflow.
   p_wflag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && wd_q) |=> !$rose(wflag_q));

   // R5: reset request never lasts two cycles.
   p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_q |=> !rst_req_q);

   // R6: interval flag rises only after an interval-mode overflow.
   p_iflag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && !wd_q) |=> !$rose(iflag_q));

   // R7: an interval overflow always leaves the flag set.
   p_ovf_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !wd_q) |=> iflag_q);

   // R8: clock select is frozen while running.
   p_csel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(csel_q));

endmodule

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned PRE_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              wdt_rst_req,
   output logic              itv_irq
);
   import wdt_pkg::*;

   if (CNT_W > DATA_W) begin : g_chk_width
      $error("wdt_dual_timer: counter wider than the register port");
   end

   logic             cnt_ld, ctl_wr, run, tick, ovf;
   logic [SEL_W-1:0] csel;
   logic [CNT_W-1:0] cnt;
   logic [DATA_W-1:0] ctl_rdata;

   assign cnt_ld = reg_wr & (reg_addr == ADDR_CNT);
   assign ctl_wr = reg_wr & (reg_addr == ADDR_CTL);

   wdt_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (csel),
      .tick (tick)
   );

   wdt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .ld    (cnt_ld),
      .ld_val(reg_wdata[CNT_W-1:0]),
      .cnt   (cnt),
      .ovf   (ovf)
   );

   wdt_ctrl_regs #(.DATA_W(DATA_W)) i_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctl_wr),
      .wdata  (reg_wdata),
      .ovf    (ovf),
      .run    (run),
      .csel   (csel),
      .rdata  (ctl_rdata),
      .rst_req(wdt_rst_req),
      .irq    (itv_irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_CNT) reg_rdata[CNT_W-1:0] = cnt;
      else                      reg_rdata = ctl_rdata;
   end

endmodule

// File: tb/test_wdt_dual_timer.sv
module test_wdt_dual_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       wdt_rst_req;
   logic       itv_irq;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   int rst_hi = 0;

   always #4 clk = ~clk;

   wdt_dual_timer i_wdt_dual_timer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wdt_rst_req(wdt_rst_req), .itv_irq(itv_irq)
   );

   always @(negedge clk) if (rst_n && wdt_rst_req) rst_hi++;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ctl(input bit wd, input bit en, input bit wf,
                                      input bit itf, input int cs);
      return {wd, en, 1'b0, wf, itf, cs[2:0]};
   endfunction

   function automatic int ratio(input int code);
      int r [8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
      return r[code];
   endfunction

   // Called at a negedge; captured at the next posedge; returns at the following negedge.
   task automatic wr(input logic a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output int v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int v, a, b, first, gap;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      rd(1'b0, v); check("R1 counter", v, 0);
      rd(1'b1, v); check("R1 control", v, 0);
      check("R1 rst_req", wdt_rst_req, 0);
      check("R1 irq", itv_irq, 0);

      // R2 / R8 / R10: sweep every clock-select code
      for (int k = 0; k < 8; k++) begin
         wr(1'b1, ctl(0, 0, 1, 1, k));
         wr(1'b0, 8'h00);
         wr(1'b1, ctl(0, 1, 1, 1, k));
         rd(1'b1, v); check("R8 csel accepted while stopped", v, ctl(0, 1, 0, 0, k));
         rd(1'b0, first);
         for (int n = 0; n < 5000; n++) begin
            @(negedge clk); rd(1'b0, v);
            if (v != first) break;
         end
         first = v; gap = 0;
         for (int n = 0; n < 5000; n++) begin
            @(negedge clk); rd(1'b0, v); gap++;
            if (v != first) break;
         end
         check($sformatf("R2 spacing code %0d", k), gap, ratio(k));
         check("R2 step of one", v, (first + 1) & 8'hFF);
      end

      // R5 / R4 watchdog overflow
      wr(1'b1, ctl(1, 0, 0, 0, 0));
      wr(1'b0, 8'hFD);
      wr(1'b1, ctl(1, 1, 1, 1, 0));
      step(2);
      rd(1'b0, v); check("R4 at max", v, 8'hFF);
      check("R5 no early reset", wdt_rst_req, 0);
      step(1);
      rd(1'b0, v); check("R4 wrap to zero", v, 0);
      check("R5 reset pulse", wdt_rst_req, 1);
      step(1);
      rd(1'b0, v); check("R4 keeps counting", v, 1);
      check("R5 pulse one cycle", wdt_rst_req, 0);
      check("R5 pulse count", rst_hi, 1);
      rd(1'b1, v); check("R5 flags after watchdog ovf", v, ctl(1, 1, 1, 0, 0));
      check("R5 no irq", itv_irq, 0);

      // R7 write 1 keeps, write 0 clears
      wr(1'b1, ctl(1, 0, 1, 1, 0));
      rd(1'b1, v); check("R7 write one keeps", v, ctl(1, 0, 1, 0, 0));
      wr(1'b1, ctl(1, 0, 0, 1, 0));
      rd(1'b1, v); check("R7 write zero clears", v, ctl(1, 0, 0, 0, 0));

      // R6 interval overflow
      wr(1'b1, ctl(0, 0, 1, 1, 0));
      wr(1'b0, 8'hFD);
      wr(1'b1, ctl(0, 1, 1, 1, 0));
      step(3);
      rd(1'b0, v); check("R6 wrap to zero", v, 0);
      check("R6 irq raised", itv_irq, 1);
      rd(1'b1, v); check("R6 flags after interval ovf", v, ctl(0, 1, 0, 1, 0));
      step(5);
      check("R6 irq stays high", itv_irq, 1);
      check("R6 no reset pulse", rst_hi, 1);
      wr(1'b1, ctl(0, 1, 1, 1, 0));
      check("R7 irq kept by write one", itv_irq, 1);
      wr(1'b1, ctl(0, 1, 1, 0, 0));
      check("R7 irq dropped by clear", itv_irq, 0);

      // R8 csel write while running is ignored
      wr(1'b1, ctl(0, 1, 1, 1, 5));
      rd(1'b1, v); check("R8 csel frozen", v, ctl(0, 1, 0, 0, 0));
      rd(1'b0, a); step(1); rd(1'b0, b);
      check("R8 rate unchanged", b, (a + 1) & 8'hFF);

      // R9 load beats increment
      wr(1'b0, 8'h40);
      rd(1'b0, v); check("R9 load value", v, 8'h40);
      step(1);
      rd(1'b0, v); check("R9 counts after load", v, 8'h41);

      // R7 overflow coincident with clear
      wr(1'b0, 8'hFF);
      wr(1'b1, ctl(0, 1, 1, 0, 0));
      check("R7 overflow beats clear irq", itv_irq, 1);
      rd(1'b1, v); check("R7 overflow beats clear flag", v, ctl(0, 1, 0, 1, 0));
      rd(1'b0, v); check("R4 wrap on coincident clear", v, 0);

      // R3 stopped counter holds
      wr(1'b1, ctl(0, 0, 1, 1, 0));
      rd(1'b0, a); step(20); rd(1'b0, b);
      check("R3 hold while stopped", b, a);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule